// File: doc/BRIEF.md
# Predicated Execution Mode Unit

This unit holds the execute-enable state of a small processor whose conditional behaviour is driven by a mode and not by branches. A dedicated condition-setting instruction carries a 3-bit code. When decode marks such an instruction, the unit tests the code against the current Zero and Carry flags. It then stores the outcome as a persistent enable bit. That bit governs every later instruction until the next condition-setting instruction replaces it. With this scheme, short if/else sequences run straight through without a jump.

While the enable bit is low, the fetch logic and the program counter keep running. However, every architectural write request is suppressed: register writes, memory writes and flag updates arrive on parallel request lanes and leave the unit masked. The condition-setting instruction is evaluated in every state. This includes the disabled state, so a disabled region can always be left. Decode and flag generation live outside this unit.

The flags follow a compare of a nominated register against the implicit operand register. Zero means the two were equal. Carry means the implicit operand was greater than the register.

Top module: `pred_cond_unit`

## Requirements
- R1: A synchronous active-high reset drives `exec_en` to 1 (unconditional execution) on the next clock edge.
- R2: Code 3'b000 (always) sets `exec_en` to 1 whatever the flags are.
- R3: Code 3'b001 (equal) sets `exec_en` to the value of `flag_z`.
- R4: Code 3'b010 (not equal) sets `exec_en` to the inverse of `flag_z`.
- R5: Code 3'b011 (implicit operand strictly greater) sets `exec_en` to `flag_c` AND NOT `flag_z`.
- R6: Code 3'b100 (implicit operand strictly less) sets `exec_en` to NOT `flag_c` AND NOT `flag_z`.
- R7: Code 3'b101 (greater or equal) sets `exec_en` to `flag_c` OR `flag_z`; code 3'b110 (less or equal) sets it to NOT `flag_c`.
- R8: Code 3'b111 (never) clears `exec_en` whatever the flags are.
- R9: When `cond_valid` is low, `exec_en` holds its value, and changes on `cond_code`, `flag_z` and `flag_c` have no effect on it.
- R10: A condition-setting instruction is evaluated even while `exec_en` is 0.
- R11: The new `exec_en` appears on the clock edge that samples `cond_valid` high: one cycle of latency.
- R12: Each bit of `wr_gated` equals the matching bit of `wr_req` when `exec_en` is 1, and all bits are 0 when `exec_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_valid | input | 1 | Strobe marking a condition-setting instruction |
| cond_code | input | 3 | Condition code of that instruction |
| flag_z | input | 1 | Zero flag (operands equal) |
| flag_c | input | 1 | Carry flag (implicit operand greater) |
| wr_req | input | LANES | Architectural write requests (register, memory, flags, ...) |
| exec_en | output | 1 | Registered execute-enable |
| wr_gated | output | LANES | Write requests masked by the execute-enable |

## Verification
The bench builds the unit with `LANES` set to 4 rather than the default of 3. This shows that the masking generate loop scales, and it lets a four-bit request pattern expose a lane that is wired wrongly or left unmasked. Each of the eight codes is driven against all four flag combinations. The sequences also cover strobe-free cycles with changing flags, leaving the disabled state, and a reset issued while the unit is disabled.

// File: rtl/pred_pkg.sv
package pred_pkg;

  localparam int COND_W = 3;

  typedef enum logic [COND_W-1:0] {
    CC_ALWAYS = 3'd0,
    CC_EQ     = 3'd1,
    CC_NE     = 3'd2,
    CC_GT     = 3'd3,
    CC_LT     = 3'd4,
    CC_GE     = 3'd5,
    CC_LE     = 3'd6,
    CC_NEVER  = 3'd7
  } cond_code_e;

endpackage

// File: rtl/pred_cond_eval.sv
module pred_cond_eval
  import pred_pkg::*;
(
  input  cond_code_e code,
  input  logic       zf,
  input  logic       cf,
  output logic       pass
);

  // Carry marks the implicit operand as the larger one, zero marks equality.
  always_comb begin
    unique case (code)
      CC_ALWAYS: pass = 1'b1;
      CC_EQ:     pass = zf;
      CC_NE:     pass = ~zf;
      CC_GT:     pass = cf & ~zf;
      CC_LT:     pass = ~cf & ~zf;
      CC_GE:     pass = cf | zf;
      CC_LE:     pass = ~cf;
      CC_NEVER:  pass = 1'b0;
      default:   pass = 1'b1;
    endcase
  end

endmodule

// File: rtl/pred_mode_reg.sv
module pred_mode_reg
  import pred_pkg::*;
#(
  parameter logic RESET_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       pass_in,
  input  cond_code_e code,
  input  logic       zf,
  input  logic       cf,
  output logic       en_q
);

  // The mode register loads on every condition strobe, whatever its state.
  always_ff @(posedge clk) begin
    if (rst)       en_q <= RESET_EN;
    else if (load) en_q <= pass_in;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(en_q));

  p_always_r2: assert property (@(posedge clk) disable iff (rst)
    (load && code == CC_ALWAYS) |=> en_q);

  p_never_r8: assert property (@(posedge clk) disable iff (rst)
    (load && code == CC_NEVER) |=> !en_q);

  p_eq_r3: assert property (@(posedge clk) disable iff (rst)
    (load && code == CC_EQ) |=> (en_q == $past(zf)));

  p_gt_r5: assert property (@(posedge clk) disable iff (rst)
    (load && code == CC_GT) |=> (en_q == ($past(cf) && !$past(zf))));

  p_leave_r10: assert property (@(posedge clk) disable iff (rst)
    (!en_q && load && code == CC_ALWAYS) |=> en_q);

endmodule

// File: rtl/pred_lane_gate.sv
module pred_lane_gate #(
  parameter int LANES = 3
) (
  input  logic             en,
  input  logic [LANES-1:0] req,
  output logic [LANES-1:0] gated
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign gated[i] = req[i] & en;
  end

endmodule

// File: rtl/pred_cond_unit.sv
module pred_cond_unit
  import pred_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cond_valid,
  input  logic [2:0]       cond_code,
  input  logic             flag_z,
  input  logic             flag_c,
  input  logic [LANES-1:0] wr_req,
  output logic             exec_en,
  output logic [LANES-1:0] wr_gated
);

  cond_code_e code_e;
  logic       pass;

  assign code_e = cond_code_e'(cond_code);

  pred_cond_eval u_eval (
    .code (code_e),
    .zf   (flag_z),
    .cf   (flag_c),
    .pass (pass)
  );

  pred_mode_reg #(.RESET_EN(1'b1)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .load    (cond_valid),
    .pass_in (pass),
    .code    (code_e),
    .zf      (flag_z),
    .cf      (flag_c),
    .en_q    (exec_en)
  );

  pred_lane_gate #(.LANES(LANES)) u_gate (
    .en    (exec_en),
    .req   (wr_req),
    .gated (wr_gated)
  );

  p_mask_r12: assert property (@(posedge clk) disable iff (rst)
    !exec_en |-> (wr_gated == '0));

  p_pass_r12: assert property (@(posedge clk) disable iff (rst)
    exec_en |-> (wr_gated == wr_req));

endmodule

// File: tb/pred_cond_unit_bench.sv
`timescale 1ns/100ps
module pred_cond_unit_bench;

  localparam int LANES = 4;

  typedef struct {
    int               due;
    logic             en;
    logic [LANES-1:0] we;
    string            tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cond_valid = 1'b0;
  logic [2:0]       cond_code = 3'd0;
  logic             flag_z = 1'b0;
  logic             flag_c = 1'b0;
  logic [LANES-1:0] wr_req = '0;
  logic             exec_en;
  logic [LANES-1:0] wr_gated;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;
  logic model_en = 1'b1;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pred_cond_unit #(.LANES(LANES)) u_pred_cond_unit (
    .clk, .rst, .cond_valid, .cond_code, .flag_z, .flag_c,
    .wr_req, .exec_en, .wr_gated
  );

  // Expected outcome per code, taken from the requirement list.
  function automatic logic expect_pass(logic [2:0] c, logic z, logic cy);
    case (c)
      3'b000:  return 1'b1;          // R2
      3'b001:  return z;             // R3
      3'b010:  return !z;            // R4
      3'b011:  return cy && !z;      // R5
      3'b100:  return !cy && !z;     // R6
      3'b101:  return cy || z;       // R7
      3'b110:  return !cy;           // R7
      default: return 1'b0;          // R8
    endcase
  endfunction

  task automatic step(input logic r, input logic v, input logic [2:0] c,
                      input logic z, input logic cy, input logic [LANES-1:0] we,
                      input string tag);
    exp_t e;
    @(negedge clk); #1;
    rst = r; cond_valid = v; cond_code = c; flag_z = z; flag_c = cy; wr_req = we;
    if (r)      model_en = 1'b1;
    else if (v) model_en = expect_pass(c, z, cy);
    e.due = cyc + 1;
    e.en  = model_en;
    e.we  = model_en ? we : '0;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares scoreboard items at the falling edge they fall due.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (exec_en !== e.en || wr_gated !== e.we) begin
        fails++;
        $display("FAIL %s: exec_en=%b wr_gated=%b expected exec_en=%b wr_gated=%b",
                 e.tag, exec_en, wr_gated, e.en, e.we);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(1, 0, 3'd0, 0, 0, 4'hF, "R1");
    step(1, 0, 3'd0, 0, 0, 4'hA, "R1");
    step(0, 0, 3'd0, 0, 0, 4'h5, "R1");
    // Every code against every flag pair (R2..R8), with R11 latency.
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 4; f++) begin
        string t;
        case (c)
          0: t = "R2"; 1: t = "R3"; 2: t = "R4"; 3: t = "R5";
          4: t = "R6"; 5: t = "R7"; 6: t = "R7"; default: t = "R8";
        endcase
        step(0, 1, 3'(c), f[1], f[0], 4'(c * 4 + f + 1), t);
        step(0, 0, 3'(c), !f[1], !f[0], 4'hF, "R11");
      end
    end
    // Hold: disabled, flags and code wiggle with no strobe.
    step(0, 1, 3'b111, 0, 0, 4'hF, "R8");
    for (int k = 0; k < 6; k++)
      step(0, 0, 3'(k), k[0], k[1], 4'hF, "R9");
    // Leave the disabled mode.
    step(0, 1, 3'b011, 0, 1, 4'h9, "R10");
    step(0, 0, 3'b000, 1, 1, 4'hF, "R9");
    step(0, 1, 3'b001, 0, 1, 4'h6, "R10");
    step(0, 1, 3'b001, 1, 0, 4'hC, "R10");
    // Enabled: strobe-free cycles keep it enabled.
    for (int k = 0; k < 4; k++)
      step(0, 0, 3'b111, k[0], k[1], 4'(k * 5), "R12");
    // Reset while disabled.
    step(0, 1, 3'b111, 1, 1, 4'hF, "R8");
    step(1, 0, 3'b111, 0, 0, 4'hF, "R1");
    step(0, 0, 3'b000, 0, 0, 4'h3, "R1");
    step(0, 0, 3'b000, 0, 0, 4'h0, "R12");
    repeat (3) @(negedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule